// File: doc/BRIEF.md
# Bus Parity Error Injector

This block sits in the data path of an on-chip bus and produces the per-byte parity that travels with each data beat. For fault testing it can also corrupt that parity on purpose, exactly once. Software loads a 32-bit control word through a simple write port. The word holds a 16-bit flip mask, a 4-bit source identifier and an arm flag. While the block is armed, it watches for the opening beat of a transaction whose source matches the stored identifier. On that beat it XORs the mask into the generated parity and then disarms itself.

Beats that follow within the same transaction are not altered, and neither are transactions from other sources. Software can only set the arm flag; the hardware alone clears it, one clock after the corrupted beat. To hit a chosen transaction, software writes the control word just before that transaction starts on the bus. The parity output is combinational from the beat inputs, so the block adds no latency to the data path.

Top module: `parity_fault_injector`

## Requirements
- R1: After reset, the control word reads back as 32'h0000_0000.
- R2: The flip mask is written and read at bits 31:16 and the source identifier at bits 7:4. Bits 15:8 and 3:1 always read as zero, whatever value was written to them.
- R3: When no injection fires, parity bit k equals the XOR of data bits 8k+7 to 8k. This is even parity per byte, over 16 bytes of a 128-bit beat.
- R4: An injection fires on a beat where the arm flag (bit 0) is set, the beat is valid, the transaction-start strobe is high and the beat's source identifier equals the stored one. On that beat the output parity is the generated parity XOR the flip mask.
- R5: A transaction from a source whose identifier differs from the stored one passes with correct parity and leaves the block armed.
- R6: A beat without the start strobe, or a start strobe without the valid qualifier, never carries injected parity.
- R7: The arm flag reads as 0 from the cycle after the injecting beat onward. A later matching transaction therefore passes unmodified.
- R8: A software write with bit 0 clear does not clear an armed flag.
- R9: If a write that sets bit 0 lands in the same cycle as an injection, the flag still ends up cleared.
- R10: Mask bit 16+k flips only parity bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| cfg_rd_data | output | 32 | Current control word |
| beat_valid | input | 1 | Data beat qualifier |
| beat_first | input | 1 | Marks the first data beat of a transaction |
| beat_src_id | input | 4 | Identifier of the unit sourcing the beat |
| beat_data | input | 128 | Beat data |
| beat_parity | output | 16 | Per-byte parity, possibly corrupted |

## Verification
The assertions assume that beat_first is only ever meaningful together with beat_valid. They also assume that the data, identifier and strobes are settled for the whole cycle in which they are sampled, because the parity output is combinational from them. The stimulus changes every bus and register input once per cycle, at the falling edge, and it includes a start strobe without valid to show that such a beat stays harmless. Expected parity is rebuilt from the byte data in both the checker and the bench. Neither relies on the generator inside the design.

// File: rtl/pfi_pkg.sv
// Package: shared layout of the injector control word.
// Assumes a 32-bit control word with fixed field positions.
package pfi_pkg;
    localparam int CFG_W    = 32;
    localparam int ARM_BIT  = 0;
    localparam int ID_LSB   = 4;
    localparam int MASK_LSB = 16;
endpackage

// File: rtl/pfi_ctrl_reg.sv
// Module: control word storage. Holds the mask, the source identifier and
// the arm flag. Software may set arm; only hw_clear removes it, and
// hw_clear wins over a coincident set. Assumes MASK_LSB + PAR_W <= CFG_W.
module pfi_ctrl_reg
    import pfi_pkg::*;
#(
    parameter int PAR_W = 16,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             hw_clear,
    output logic [PAR_W-1:0] mask_q,
    output logic [ID_W-1:0]  id_q,
    output logic             arm_q,
    output logic [CFG_W-1:0] rd_data
);
    // Purpose: capture mask and identifier on software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            id_q   <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data[MASK_LSB +: PAR_W];
            id_q   <= wr_data[ID_LSB +: ID_W];
        end
    end

    // Purpose: arm flag, set by software and cleared by hardware (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (hw_clear)
            arm_q <= 1'b0;
        else if (wr_en && wr_data[ARM_BIT])
            arm_q <= 1'b1;
    end

    // Purpose: assemble the readback word with reserved bits at zero.
    always_comb begin
        rd_data                      = '0;
        rd_data[MASK_LSB +: PAR_W]   = mask_q;
        rd_data[ID_LSB +: ID_W]      = id_q;
        rd_data[ARM_BIT]             = arm_q;
    end
endmodule

// File: rtl/pfi_parity_gen.sv
// Module: per-byte even parity generator. Each output bit is the XOR of
// one byte lane. Assumes DATA_W is a multiple of BYTE_W.
module pfi_parity_gen #(
    parameter int DATA_W = 128,
    parameter int BYTE_W = 8,
    localparam int PAR_W = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  parity
);
    // Purpose: one XOR reduction per byte lane.
    for (genvar g = 0; g < PAR_W; g++) begin : g_lane
        assign parity[g] = ^data[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/pfi_inject_path.sv
// Module: match logic and parity corruption. Fires on a valid first beat
// from the stored source while armed, and XORs the mask into the parity.
// Assumes all inputs are stable within the cycle.
module pfi_inject_path #(
    parameter int PAR_W = 16,
    parameter int ID_W  = 4
) (
    input  logic             beat_valid,
    input  logic             beat_first,
    input  logic [ID_W-1:0]  beat_src_id,
    input  logic [ID_W-1:0]  id_q,
    input  logic             arm_q,
    input  logic [PAR_W-1:0] mask_q,
    input  logic [PAR_W-1:0] clean_par,
    output logic             fire,
    output logic [PAR_W-1:0] par_out
);
    logic id_match;

    // Purpose: qualify the injection event.
    always_comb begin
        id_match = (beat_src_id == id_q);
        fire     = arm_q && beat_valid && beat_first && id_match;
    end

    // Purpose: apply the mask only on the firing beat.
    always_comb begin
        par_out = fire ? (clean_par ^ mask_q) : clean_par;
    end
endmodule

// File: rtl/parity_fault_injector.sv
// Module: top of the bus parity error injector. Generates per-byte parity
// for each beat and corrupts it once on the chosen transaction.
// Assumes a single clock and synchronous active-low reset.
module parity_fault_injector
    import pfi_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int BYTE_W = 8,
    parameter int ID_W   = 4,
    localparam int PAR_W = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              beat_valid,
    input  logic              beat_first,
    input  logic [ID_W-1:0]   beat_src_id,
    input  logic [DATA_W-1:0] beat_data,
    output logic [PAR_W-1:0]  beat_parity
);
    logic [PAR_W-1:0] mask_q;
    logic [ID_W-1:0]  id_q;
    logic             arm_q;
    logic             fire;
    logic [PAR_W-1:0] clean_par;

    pfi_ctrl_reg #(.PAR_W(PAR_W), .ID_W(ID_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .hw_clear (fire),
        .mask_q   (mask_q),
        .id_q     (id_q),
        .arm_q    (arm_q),
        .rd_data  (cfg_rd_data)
    );

    pfi_parity_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_gen (
        .data   (beat_data),
        .parity (clean_par)
    );

    pfi_inject_path #(.PAR_W(PAR_W), .ID_W(ID_W)) u_inj (
        .beat_valid  (beat_valid),
        .beat_first  (beat_first),
        .beat_src_id (beat_src_id),
        .id_q        (id_q),
        .arm_q       (arm_q),
        .mask_q      (mask_q),
        .clean_par   (clean_par),
        .fire        (fire),
        .par_out     (beat_parity)
    );
endmodule

// File: rtl/pfi_checker.sv
// Module: assertion checker for the injector, bound to the top. Rebuilds
// the clean parity from the data on its own and uses only top ports.
module pfi_checker #(
    parameter int DATA_W = 128,
    parameter int BYTE_W = 8,
    parameter int ID_W   = 4,
    localparam int PAR_W = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [31:0]       cfg_wr_data,
    input logic [31:0]       cfg_rd_data,
    input logic              beat_valid,
    input logic              beat_first,
    input logic [ID_W-1:0]   beat_src_id,
    input logic [DATA_W-1:0] beat_data,
    input logic [PAR_W-1:0]  beat_parity
);
    function automatic logic [PAR_W-1:0] byte_par(input logic [DATA_W-1:0] d);
        logic [PAR_W-1:0] p;
        for (int i = 0; i < PAR_W; i++) begin
            p[i] = 1'b0;
            for (int b = 0; b < BYTE_W; b++) p[i] = p[i] ^ d[i*BYTE_W + b];
        end
        return p;
    endfunction

    logic hit;
    assign hit = cfg_rd_data[0] && beat_valid && beat_first
                 && (beat_src_id == cfg_rd_data[4 +: ID_W]);

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> cfg_rd_data == 32'h0);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[15:8] == 8'h0 && cfg_rd_data[3:1] == 3'h0);

    p_clean_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> beat_parity == byte_par(beat_data));

    p_inject_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> beat_parity == (byte_par(beat_data) ^ cfg_rd_data[31:16]));

    p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !cfg_rd_data[0]);

    p_arm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[0] && !hit) |=> cfg_rd_data[0]);

    p_arm_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_data[0] && !hit) |=> cfg_rd_data[0]);
endmodule

bind parity_fault_injector pfi_checker #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ID_W(ID_W)
) u_pfi_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .beat_valid  (beat_valid),
    .beat_first  (beat_first),
    .beat_src_id (beat_src_id),
    .beat_data   (beat_data),
    .beat_parity (beat_parity)
);

// File: tb/parity_fault_injector_test.sv
// Bench: table-driven stimulus followed by directed reset and readback tests.
module parity_fault_injector_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [31:0]  cfg_wr_data = '0;
    logic [31:0]  cfg_rd_data;
    logic         beat_valid = 1'b0;
    logic         beat_first = 1'b0;
    logic [3:0]   beat_src_id = '0;
    logic [127:0] beat_data = '0;
    logic [15:0]  beat_parity;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    parity_fault_injector uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .beat_valid(beat_valid), .beat_first(beat_first),
        .beat_src_id(beat_src_id), .beat_data(beat_data), .beat_parity(beat_parity)
    );

    typedef struct packed {
        logic         wr;
        logic [31:0]  wd;
        logic         valid;
        logic         first;
        logic [3:0]   id;
        logic [127:0] data;
        logic [15:0]  xr;
        logic         arm;
    } vec_t;

    localparam logic [127:0] D1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] D2 = 128'hDEAD_BEEF_0000_FFFF_1357_9BDF_2468_ACE0;
    localparam logic [127:0] D3 = 128'h8000_0000_0000_0001_0F0F_F0F0_AAAA_5555;
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h00A5_0051, 1'b0, 1'b0, 4'h0, D1, 16'h0000, 1'b1}, // arm, id 5
        '{1'b0, 32'h0,         1'b1, 1'b1, 4'h3, D1, 16'h0000, 1'b1}, // R5 other source
        '{1'b0, 32'h0,         1'b1, 1'b0, 4'h5, D2, 16'h0000, 1'b1}, // R6 not first
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'h5, D3, 16'h0000, 1'b1}, // R6 no valid
        '{1'b1, 32'h00A5_0050, 1'b0, 1'b0, 4'h0, D2, 16'h0000, 1'b1}, // R8 write 0 to arm
        '{1'b0, 32'h0,         1'b1, 1'b1, 4'h5, D2, 16'h00A5, 1'b0}, // R4 fire, R7
        '{1'b0, 32'h0,         1'b1, 1'b0, 4'h5, D3, 16'h0000, 1'b0}, // R6 later beat
        '{1'b0, 32'h0,         1'b1, 1'b1, 4'h5, D1, 16'h0000, 1'b0}, // R7 no refire
        '{1'b1, 32'h8001_0021, 1'b0, 1'b0, 4'h0, D3, 16'h0000, 1'b1}, // arm, id 2
        '{1'b1, 32'h8001_0021, 1'b1, 1'b1, 4'h2, D3, 16'h8001, 1'b0}, // R9 set vs clear
        '{1'b0, 32'h0,         1'b1, 1'b1, 4'h2, D2, 16'h0000, 1'b0}, // R9 stays clear
        '{1'b1, 32'h0004_00F1, 1'b0, 1'b0, 4'h0, D1, 16'h0000, 1'b1}, // R10 single bit
        '{1'b0, 32'h0,         1'b1, 1'b1, 4'hF, D1, 16'h0004, 1'b0}  // R10 flips bit 2
    };

    function automatic logic [15:0] ref_par(input logic [127:0] d);
        logic [15:0] p;
        for (int i = 0; i < 16; i++) begin
            p[i] = 1'b0;
            for (int b = 0; b < 8; b++) p[i] = p[i] ^ d[8*i + b];
        end
        return p;
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check32("R1 reset word", cfg_rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check32("R1 after release", cfg_rd_data, 32'h0);

        // Table walk: parity checked mid-cycle, arm checked after the edge.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_wr_en   = VECS[v].wr;
            cfg_wr_data = VECS[v].wd;
            beat_valid  = VECS[v].valid;
            beat_first  = VECS[v].first;
            beat_src_id = VECS[v].id;
            beat_data   = VECS[v].data;
            #1;
            check32($sformatf("R3/R4/R5/R6/R10 parity vec %0d", v),
                    {16'h0, beat_parity}, {16'h0, ref_par(VECS[v].data) ^ VECS[v].xr});
            @(posedge clk);
            #1;
            check32($sformatf("R7/R8/R9 arm vec %0d", v),
                    {31'h0, cfg_rd_data[0]}, {31'h0, VECS[v].arm});
        end

        // R2: all ones written, reserved bits read zero.
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = 32'hFFFF_FFFF;
        beat_valid = 1'b0; beat_first = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check32("R2 readback all ones", cfg_rd_data, 32'hFFFF_00F1);
        // R2: field values land in their slots.
        cfg_wr_en = 1'b1; cfg_wr_data = 32'h1234_5678;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check32("R2 readback pattern", cfg_rd_data, 32'h1234_0071);
        // R1: reset while armed clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        check32("R1 reset while armed", cfg_rd_data, 32'h0);
        rst_n = 1'b1;
        // R3: unarmed, matching first beat with id 0 passes clean parity.
        beat_valid = 1'b1; beat_first = 1'b1; beat_src_id = 4'h0; beat_data = D3;
        #1;
        check32("R3 unarmed id 0", {16'h0, beat_parity}, {16'h0, ref_par(D3)});
        @(negedge clk);
        beat_valid = 1'b0; beat_first = 1'b0;
        finish_run();
    end
endmodule